// File: doc/BRIEF.md
# Serial-Loaded Static LCD Segment Driver

This block drives a static (non-multiplexed) liquid crystal panel with 38 segment outputs. Display data arrives one bit at a time on a serial input. A bit is accepted on each falling edge of a shift clock, and only while an active-low select is asserted. A load level copies the shift register into an output latch. If load is held high while bits are shifted, the latch is transparent and follows the shift register.

Each segment output is its latched bit XORed with a backplane square wave. A latched 1 therefore drives the segment in antiphase with the backplane, which turns it on. A latched 0 keeps the segment in phase, which leaves it off. The backplane comes from one of two sources, chosen by a mode input:

- an external display clock, passed through unchanged;
- an oscillator input divided by 256.

Several drivers can be chained. They share the shift clock, the select and the load lines. Each driver's serial output feeds the next driver's serial input. The serial output is taken from a tap at position 30, 32, 34 or 38 of the shift register, and it changes on the rising edge of the shift clock. The next driver can therefore sample it on the following falling edge.

All inputs are sampled by one system clock. The shift clock and the oscillator are treated as slow level inputs, and their edges are detected against that system clock.

Top module: `lcdseg_driver`

## Requirements
- R1: When the shift clock goes from 1 to 0 while `csN` is 0, the value of `dataIn` enters shift position 1 (bit 0), and every other bit moves one position toward position 38 (bit 37).
- R2: While `csN` is 1, a falling edge of the shift clock leaves the shift register unchanged.
- R3: `dataOut` changes only after a rising edge of the shift clock, when it takes the bit at the selected tap. Between a falling edge and the next rising edge it keeps its earlier value.
- R4: `tapSel` selects the tap position as follows: 2'b00 selects position 30 (bit 29), 2'b01 selects position 32, 2'b10 selects position 34, and 2'b11 selects position 38 (bit 37).
- R5: While `load` is 1, the latch takes the shift register contents. If `load` stays 1 during shifting, the latch follows every shift.
- R6: While `load` is 0, the latch holds its contents, whatever the shift activity.
- R7: Each `seg[i]` equals latch bit i XOR `backplane`.
- R8: When `oscMode` is 0, `backplane` equals `dispClk`, in phase and with no division.
- R9: When `oscMode` is 1, `backplane` is the most significant bit of an 8-bit counter. The counter advances on each rising edge of `oscIn` and wraps from 255 to 0. So `backplane` is 1 after 128 to 255 edges and 0 again after 256 edges.
- R10: An asynchronous low `rstN` clears the shift register, the latch, `dataOut` and the divider counter.
- R11: In a chain of two drivers, with the second driver's `dataIn` tied to the first driver's `dataOut`, the second driver receives the first driver's tap stream, delayed by one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Select, active low; gates shifting |
| shiftClk | input | 1 | Shift clock; idles high, shifts on its falling edge |
| dataIn | input | 1 | Serial data input |
| load | input | 1 | Latch load level; the latch is transparent while high |
| tapSel | input | 2 | Selects the cascade tap position |
| oscMode | input | 1 | Backplane source: 0 selects the external clock, 1 selects the divided oscillator |
| dispClk | input | 1 | External display clock |
| oscIn | input | 1 | Oscillator input for the divide-by-256 path |
| dataOut | output | 1 | Serial output from the selected tap |
| backplane | output | 1 | Backplane square wave |
| seg | output | 38 | Segment drive levels |

## Verification
The assertions take these things for granted about the inputs:

- every input is synchronous to `clk`;
- every input holds each level for at least one `clk` cycle, so that no edge of the shift clock or the oscillator is missed;
- the shift clock is high when reset is released.

The bench keeps within these limits. It changes inputs only on the falling edge of `clk`, and it holds each shift-clock and oscillator level for at least one full cycle. It leaves `shiftClk` high and `oscIn` low around every reset.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  localparam int SEG_COUNT = 38;
  localparam int DIV_BITS  = 8;

  typedef struct packed {
    logic shiftEn;   // accept one serial bit
    logic outUpd;    // refresh the serial output register
    logic ldEn;      // copy shift register into the latch
    logic divTick;   // advance the backplane divider
  } lcdStrobes_t;

  typedef enum logic [1:0] {
    TAP_30 = 2'b00,
    TAP_32 = 2'b01,
    TAP_34 = 2'b10,
    TAP_38 = 2'b11
  } tapSel_e;

  function automatic int tapPosition(input logic [1:0] sel);
    case (tapSel_e'(sel))
      TAP_30:  return 30;
      TAP_32:  return 32;
      TAP_34:  return 34;
      default: return 38;
    endcase
  endfunction

endpackage

// File: rtl/lcdseg_ctrl.sv
module lcdseg_ctrl
  import lcdseg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        shiftClk,
  input  logic        load,
  input  logic        oscIn,
  output lcdStrobes_t strobes
);

  logic shiftClkQ;
  logic oscInQ;

  // Edge history; both start high so reset release never fakes a falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftClkQ <= 1'b1;
      oscInQ    <= 1'b1;
    end else begin
      shiftClkQ <= shiftClk;
      oscInQ    <= oscIn;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.shiftEn = shiftClkQ & ~shiftClk & ~csN;
    strobes.outUpd  = ~shiftClkQ & shiftClk;
    strobes.ldEn    = load;
    strobes.divTick = ~oscInQ & oscIn;
  end

endmodule

// File: rtl/lcdseg_datapath.sv
module lcdseg_datapath
  import lcdseg_pkg::*;
#(
  parameter int NumSeg  = SEG_COUNT,
  parameter int DivBits = DIV_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  lcdStrobes_t        strobes,
  input  logic               dataIn,
  input  logic [1:0]         tapSel,
  input  logic               oscMode,
  input  logic               dispClk,
  output logic               dataOut,
  output logic               backplane,
  output logic [NumSeg-1:0]  seg,
  output logic [NumSeg-1:0]  shiftVec,
  output logic [NumSeg-1:0]  latchVec,
  output logic [DivBits-1:0] divCnt
);

  localparam int NumTaps = 4;

  logic [NumSeg-1:0]  shiftQ;
  logic [NumSeg-1:0]  shiftNext;
  logic [NumSeg-1:0]  latchQ;
  logic [NumTaps-1:0] tapBits;
  logic               outQ;
  logic [DivBits-1:0] divQ;
  logic               bpLevel;

  assign shiftNext = strobes.shiftEn ? {shiftQ[NumSeg-2:0], dataIn} : shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else begin
      shiftQ <= shiftNext;
    end
  end

  // The latch samples the post-shift value, so a held load tracks every shift.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (strobes.ldEn) begin
      latchQ <= shiftNext;
    end
  end

  for (genvar k = 0; k < NumTaps; k++) begin : g_tap
    localparam int Pos = tapPosition(2'(k));
    assign tapBits[k] = shiftQ[Pos-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= 1'b0;
    end else if (strobes.outUpd) begin
      outQ <= tapBits[tapSel];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (strobes.divTick) begin
      divQ <= divQ + 1'b1;
    end
  end

  assign bpLevel = oscMode ? divQ[DivBits-1] : dispClk;

  for (genvar i = 0; i < NumSeg; i++) begin : g_seg
    assign seg[i] = latchQ[i] ^ bpLevel;
  end

  assign dataOut   = outQ;
  assign backplane = bpLevel;
  assign shiftVec  = shiftQ;
  assign latchVec  = latchQ;
  assign divCnt    = divQ;

endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
  import lcdseg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 shiftClk,
  input  logic                 dataIn,
  input  logic                 load,
  input  logic [1:0]           tapSel,
  input  logic                 oscMode,
  input  logic                 dispClk,
  input  logic                 oscIn,
  output logic                 dataOut,
  output logic                 backplane,
  output logic [SEG_COUNT-1:0] seg
);

  lcdStrobes_t          strobes;
  logic [SEG_COUNT-1:0] shiftVec;
  logic [SEG_COUNT-1:0] latchVec;
  logic [DIV_BITS-1:0]  divCnt;

  lcdseg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .shiftClk (shiftClk),
    .load     (load),
    .oscIn    (oscIn),
    .strobes  (strobes)
  );

  lcdseg_datapath #(
    .NumSeg  (SEG_COUNT),
    .DivBits (DIV_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .tapSel    (tapSel),
    .oscMode   (oscMode),
    .dispClk   (dispClk),
    .dataOut   (dataOut),
    .backplane (backplane),
    .seg       (seg),
    .shiftVec  (shiftVec),
    .latchVec  (latchVec),
    .divCnt    (divCnt)
  );

endmodule

// File: rtl/lcdseg_checker.sv
module lcdseg_checker
  import lcdseg_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 shiftClk,
  input logic                 dataIn,
  input logic                 load,
  input logic                 oscIn,
  input logic                 dataOut,
  input logic [SEG_COUNT-1:0] shiftVec,
  input logic [SEG_COUNT-1:0] latchVec,
  input logic [DIV_BITS-1:0]  divCnt
);

  logic sclkPrev;
  logic oscPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      oscPrev  <= 1'b1;
    end else begin
      sclkPrev <= shiftClk;
      oscPrev  <= oscIn;
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclkPrev && !shiftClk) |=> shiftVec[0] == $past(dataIn));

  p_shift_move_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclkPrev && !shiftClk) |=>
      shiftVec[SEG_COUNT-1:1] == $past(shiftVec[SEG_COUNT-2:0]));

  p_cs_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(shiftVec));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!sclkPrev && shiftClk) |=> $stable(dataOut));

  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    load |=> latchVec == shiftVec);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(latchVec));

  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!oscPrev && oscIn) |=> $stable(divCnt));

  p_div_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!oscPrev && oscIn && divCnt == '1) |=> divCnt == '0);

endmodule

bind lcdseg_driver lcdseg_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .shiftClk (shiftClk),
  .dataIn   (dataIn),
  .load     (load),
  .oscIn    (oscIn),
  .dataOut  (dataOut),
  .shiftVec (shiftVec),
  .latchVec (latchVec),
  .divCnt   (divCnt)
);

// File: tb/tb_lcdseg_driver.sv
`timescale 1ns/1ps
module tb_lcdseg_driver;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        csN = 1'b0;
  logic        shiftClk = 1'b1;
  logic        dataIn = 1'b0;
  logic        load = 1'b0;
  logic [1:0]  tapSel = 2'b11;
  logic        oscMode = 1'b0;
  logic        dispClk = 1'b0;
  logic        oscIn = 1'b0;
  logic        outA, outB, bpA, bpB;
  logic [37:0] segA, segB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Behavioural model of the two-driver chain
  logic [37:0] upM, dnM, latA, latB;
  logic        outAM, outBM;

  lcdseg_driver dut (
    .clk(clk), .rstN(rstN), .csN(csN), .shiftClk(shiftClk), .dataIn(dataIn),
    .load(load), .tapSel(tapSel), .oscMode(oscMode), .dispClk(dispClk),
    .oscIn(oscIn), .dataOut(outA), .backplane(bpA), .seg(segA)
  );

  lcdseg_driver dutNext (
    .clk(clk), .rstN(rstN), .csN(csN), .shiftClk(shiftClk), .dataIn(outA),
    .load(load), .tapSel(tapSel), .oscMode(oscMode), .dispClk(dispClk),
    .oscIn(oscIn), .dataOut(outB), .backplane(bpB), .seg(segB)
  );

  function automatic int tapIdx(input logic [1:0] sel);
    case (sel)
      2'b00:   return 29;
      2'b01:   return 31;
      2'b10:   return 33;
      default: return 37;
    endcase
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetAll();
    @(negedge clk);
    rstN = 1'b0;
    upM = '0; dnM = '0; latA = '0; latB = '0; outAM = 1'b0; outBM = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic fallEdge(input logic b);
    @(negedge clk);
    dataIn   = b;
    shiftClk = 1'b0;
    idle(2);
    if (!csN) begin
      dnM = {dnM[36:0], outAM};
      upM = {upM[36:0], b};
    end
    if (load) begin
      latA = upM;
      latB = dnM;
    end
  endtask

  task automatic riseEdge();
    @(negedge clk);
    shiftClk = 1'b1;
    idle(2);
    outAM = upM[tapIdx(tapSel)];
    outBM = dnM[tapIdx(tapSel)];
  endtask

  task automatic shiftBit(input logic b);
    fallEdge(b);
    riseEdge();
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    load = 1'b1;
    idle(1);
    load = 1'b0;
    idle(1);
    latA = upM;
    latB = dnM;
  endtask

  task automatic checkSegs(input string tag, input logic bpExp);
    check({tag, " R7 segA"}, segA, latA ^ {38{bpExp}});
    check({tag, " R7 segB"}, segB, latB ^ {38{bpExp}});
  endtask

  function automatic logic patBit(input int i);
    return logic'(((i * 5) >> 1) ^ (i / 7)) & 1'b1;
  endfunction

  task automatic testReset();
    resetAll();
    check("R10 segA after reset", segA, '0);
    check("R10 segB after reset", segB, '0);
    check("R10 dataOut after reset", {37'b0, outA}, '0);
    check("R10 backplane after reset", {37'b0, bpA}, '0);
  endtask

  task automatic testShiftLoad();
    resetAll();
    tapSel = 2'b11;
    for (int i = 0; i < 76; i++) shiftBit(patBit(i));
    check("R6 segA before load", segA, '0);
    check("R6 segB before load", segB, '0);
    pulseLoad();
    check("R1 upstream latch after load", segA, upM);
    check("R11 downstream latch after load", segB, dnM);
    check("R3 dataOut after chain shift", {37'b0, outA}, {37'b0, outAM});
  endtask

  task automatic testCsGate();
    logic [37:0] keepA;
    keepA = segA;
    csN  = 1'b1;
    for (int i = 0; i < 4; i++) shiftBit(~keepA[37 - i]);
    load = 1'b1;
    idle(2);
    check("R2 segA after blocked shifts", segA, keepA);
    load = 1'b0;
    csN  = 1'b0;
    idle(1);
  endtask

  task automatic testTransparent();
    load = 1'b1;
    for (int i = 0; i < 3; i++) begin
      shiftBit(i != 1);
      check("R5 transparent segA", segA, upM);
    end
    checkSegs("R5 transparent", 1'b0);
    load = 1'b0;
    shiftBit(1'b1);
    check("R6 segA frozen after load drop", segA, latA);
  endtask

  task automatic testTaps();
    for (int t = 0; t < 4; t++) begin
      resetAll();
      tapSel = 2'(t);
      shiftBit(1'b1);
      for (int i = 1; i < tapIdx(tapSel); i++) shiftBit(1'b0);
      check("R4 dataOut one shift short of tap", {37'b0, outA}, '0);
      fallEdge(1'b0);
      check("R3 dataOut unchanged before rising edge", {37'b0, outA}, '0);
      riseEdge();
      check("R4 dataOut at selected tap", {37'b0, outA}, {37'b0, 1'b1});
    end
    tapSel = 2'b11;
  endtask

  task automatic testExtPhase();
    resetAll();
    for (int i = 0; i < 38; i++) shiftBit(patBit(i + 3));
    pulseLoad();
    @(negedge clk);
    dispClk = 1'b1;
    idle(1);
    check("R8 backplane follows dispClk high", {37'b0, bpA}, {37'b0, 1'b1});
    checkSegs("R7 ext high", 1'b1);
    @(negedge clk);
    dispClk = 1'b0;
    idle(1);
    check("R8 backplane follows dispClk low", {37'b0, bpA}, '0);
    checkSegs("R7 ext low", 1'b0);
  endtask

  task automatic oscPulses(input int n);
    repeat (n) begin
      @(negedge clk);
      oscIn = 1'b1;
      @(negedge clk);
      oscIn = 1'b0;
    end
    idle(1);
  endtask

  task automatic testDivider();
    oscMode = 1'b1;
    resetAll();
    for (int i = 0; i < 20; i++) shiftBit(patBit(i + 11));
    pulseLoad();
    @(negedge clk);
    dispClk = 1'b1;
    idle(1);
    check("R9 backplane ignores dispClk in osc mode", {37'b0, bpA}, '0);
    dispClk = 1'b0;
    oscPulses(127);
    check("R9 backplane low after 127 edges", {37'b0, bpA}, '0);
    oscPulses(1);
    check("R9 backplane high after 128 edges", {37'b0, bpA}, {37'b0, 1'b1});
    checkSegs("R9 osc high", 1'b1);
    oscPulses(127);
    check("R9 backplane high after 255 edges", {37'b0, bpA}, {37'b0, 1'b1});
    oscPulses(1);
    check("R9 backplane low after 256 edges", {37'b0, bpA}, '0);
    checkSegs("R9 osc low", 1'b0);
    oscMode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testShiftLoad();
    testCsGate();
    testTransparent();
    testTaps();
    testExtPhase();
    testDivider();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule